// File: doc/BRIEF.md
# Enabled Modulo-6 Counter with Sticky Carry

This block is a three-bit synchronous counter that counts 0, 1, 2, 3, 4, 5 and then returns to 0. It moves one step on a rising clock edge only when its enable input is high. When the enable is low, it keeps its value. The count output is the state register itself, read in plain binary.

A carry flag rises on the step that wraps the count from 5 to 0. The flag does not drop after one cycle. It stays high for as long as the count sits at zero, including cycles where the enable is low, and it clears on the step that takes the count from 0 to 1. A host can use it as a "cycle completed" indication that survives a stall.

The two codes the counter never uses, 6 and 7, are treated as faults. If the register ever holds one of them, the next clock edge forces it back to zero with the carry low. An active-high synchronous reset gives the same zero state.

Top module: `mod6_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes 0 and `carry` becomes 0 on that edge, whatever the value of `step_en`.
- R2: With `step_en` high at each edge, `count` (3-bit unsigned binary) follows 0, 1, 2, 3, 4, 5, 0, 1, ... with one step per edge.
- R3: With `step_en` low at an edge and `rst` low, `count` and `carry` both keep their values.
- R4: An enabled edge that takes `count` from 5 to 0 sets `carry` to 1.
- R5: Once set, `carry` stays 1 on every edge where `count` stays 0, including edges with `step_en` low.
- R6: An enabled edge that takes `count` from 0 to 1 clears `carry`. `carry` is never 1 while `count` is nonzero. Reaching zero through reset does not set `carry`.
- R7: `count` never shows 6 or 7. If the register holds 6 or 7, the next edge forces `count` to 0 and `carry` to 0, whatever the value of `step_en`.
- R8: `count` and `carry` are registered and change on the same edge. The result of the enable sampled at one edge is visible right after that edge and never earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance enable, sampled at each rising edge |
| count | output | 3 | Present count, 0 to 5, binary |
| carry | output | 1 | Sticky wrap flag; high while the count rests at zero after a 5-to-0 step |

## Verification
Every result of this block is due exactly one rising edge after the enable or reset value that causes it. Both outputs come straight from registers, with no combinational path from input to output. The bench therefore changes `step_en` and `rst` on the falling edge and reads `count` and `carry` one time unit after the next rising edge. Each read is compared against the value the requirements give for that single step. The carry cases are placed so that the one-edge latency shows up plainly: a wrap followed by several held cycles, an immediate step out of zero, and a reset taken while the carry is high.

// File: rtl/mod6_pkg.sv
package mod6_pkg;

    // Events decoded from the present count and the enable for one edge.
    typedef struct packed {
        logic wrap;        // enabled step from the last value back to zero
        logic leave_zero;  // enabled step out of zero
        logic bad_code;    // register holds a code outside the count range
    } step_ev_t;

    // Number of bits needed to hold values 0 .. modulus-1.
    function automatic int unsigned cnt_width(input int unsigned modulus);
        return (modulus < 2) ? 1 : $clog2(modulus);
    endfunction

endpackage

// File: rtl/mod6_step.sv
module mod6_step
    import mod6_pkg::*;
#(
    parameter int MODULUS = 6,
    parameter int CNT_W   = 3
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             adv,
    output logic [CNT_W-1:0] nxt,
    output step_ev_t         ev
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic in_range;

    assign in_range = (int'({1'b0, cur}) < MODULUS);

    always_comb begin
        ev  = '0;
        nxt = cur;
        if (!in_range) begin
            nxt         = ZERO;
            ev.bad_code = 1'b1;
        end else if (adv) begin
            if (cur == LAST) begin
                nxt     = ZERO;
                ev.wrap = 1'b1;
            end else begin
                nxt = cur + 1'b1;
            end
            ev.leave_zero = (cur == ZERO);
        end
    end
endmodule

// File: rtl/mod6_carry.sv
module mod6_carry
    import mod6_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  step_ev_t ev,
    output logic     carry
);
    logic carry_d;

    always_comb begin
        carry_d = carry;
        if (ev.bad_code)
            carry_d = 1'b0;
        else if (ev.wrap)
            carry_d = 1'b1;
        else if (ev.leave_zero)
            carry_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) carry <= 1'b0;
        else     carry <= carry_d;
    end

    // R4
    wrap_sets_carry_chk: assert property (@(posedge clk) disable iff (rst)
        ev.wrap |=> carry);

    // R6
    leave_clears_carry_chk: assert property (@(posedge clk) disable iff (rst)
        ev.leave_zero |=> !carry);
endmodule

// File: rtl/mod6_counter.sv
module mod6_counter
    import mod6_pkg::*;
#(
    parameter  int MODULUS = 6,
    localparam int CNT_W   = cnt_width(MODULUS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    output logic [CNT_W-1:0] count,
    output logic             carry
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MODULUS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    step_ev_t         ev;

    mod6_step #(
        .MODULUS (MODULUS),
        .CNT_W   (CNT_W)
    ) u_step (
        .cur (cnt_q),
        .adv (step_en),
        .nxt (cnt_d),
        .ev  (ev)
    );

    mod6_carry u_carry (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .carry (carry)
    );

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count == '0) && !carry);

    // R7
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'({1'b0, count}) < MODULUS);

    // R7
    bad_code_recover_chk: assert property (@(posedge clk) disable iff (rst)
        (int'({1'b0, count}) >= MODULUS) |=> (count == '0) && !carry);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(count) && $stable(carry));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && count != LAST) |=> count == CNT_W'($past(count) + 1'b1));

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && count == LAST) |=> count == '0);

    // R5
    carry_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (carry && !step_en) |=> carry);

    // R6
    carry_only_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        carry |-> count == '0);
endmodule

// File: tb/test_mod6_counter.sv
module test_mod6_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [2:0] count;
    logic       carry;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    mod6_counter i_mod6_counter (
        .clk     (clk),
        .rst     (rst),
        .step_en (step_en),
        .count   (count),
        .carry   (carry)
    );

    // Vector: {enable, expected count after the edge, expected carry after the edge}
    localparam int NVEC = 20;
    localparam logic [4:0] VEC [NVEC] = '{
        {1'b1, 3'd1, 1'b0},  // R2 step 0->1
        {1'b0, 3'd1, 1'b0},  // R3 hold
        {1'b1, 3'd2, 1'b0},
        {1'b1, 3'd3, 1'b0},
        {1'b0, 3'd3, 1'b0},  // R3 hold
        {1'b1, 3'd4, 1'b0},
        {1'b1, 3'd5, 1'b0},
        {1'b0, 3'd5, 1'b0},  // R3 hold at last value
        {1'b1, 3'd0, 1'b1},  // R4 wrap sets carry
        {1'b0, 3'd0, 1'b1},  // R5 held at zero
        {1'b0, 3'd0, 1'b1},  // R5
        {1'b0, 3'd0, 1'b1},  // R5
        {1'b1, 3'd1, 1'b0},  // R6 leave zero clears
        {1'b1, 3'd2, 1'b0},
        {1'b1, 3'd3, 1'b0},
        {1'b1, 3'd4, 1'b0},
        {1'b1, 3'd5, 1'b0},
        {1'b1, 3'd0, 1'b1},  // R4
        {1'b1, 3'd1, 1'b0},  // R6 immediate exit
        {1'b1, 3'd2, 1'b0}
    };

    task automatic chk(input string req, input logic [2:0] exp_cnt, input logic exp_car);
        checks++;
        if (count !== exp_cnt || carry !== exp_car) begin
            failures++;
            $display("FAIL %s: count=%0d carry=%0b expected count=%0d carry=%0b",
                     req, count, carry, exp_cnt, exp_car);
        end
    endtask

    // Drive at the falling edge, read one unit after the following rising edge.
    task automatic step(input logic r, input logic e);
        @(negedge clk);
        rst     = r;
        step_en = e;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int mcnt;
        int mcar;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R1 reset state", 3'd0, 1'b0);

        foreach (VEC[i]) begin
            step(1'b0, VEC[i][4]);
            chk($sformatf("R8 vector %0d", i), VEC[i][3:1], VEC[i][0]);
        end

        // R1: reset taken while carry is high and enable is high
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1);
        chk("R4 carry before reset", 3'd0, 1'b1);
        step(1'b1, 1'b1);
        chk("R1 reset overrides enable and carry", 3'd0, 1'b0);
        // R6: zero reached by reset keeps carry low while held
        step(1'b0, 1'b0);
        chk("R6 no carry after reset zero", 3'd0, 1'b0);
        step(1'b0, 1'b0);
        chk("R6 no carry after reset zero held", 3'd0, 1'b0);

        // R8: no change visible before the edge that samples the enable
        @(negedge clk);
        step_en = 1'b1;
        #2;
        chk("R8 no early change", 3'd0, 1'b0);
        @(posedge clk);
        #1;
        chk("R8 change after edge", 3'd1, 1'b0);

        // R7 and R2: long run with a mixed enable pattern, tracked by a model
        mcnt = 1;
        mcar = 0;
        for (int k = 0; k < 90; k++) begin
            logic e;
            e = ((k % 7) != 3) && ((k % 11) != 5);
            step(1'b0, e);
            if (e) begin
                if (mcnt == 5) begin mcnt = 0; mcar = 1; end
                else begin
                    if (mcnt == 0) mcar = 0;
                    mcnt = mcnt + 1;
                end
            end
            chk("R7 long run range and sequence", 3'(mcnt), 1'(mcar));
            checks++;
            if (count > 3'd5) begin
                failures++;
                $display("FAIL R7: count=%0d expected at most 5", count);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule